// File: doc/BRIEF.md
# Program Loop Watchdog Timer

This block watches for a program that has stopped making progress. Software arms it through two write-only registers, then keeps it quiet by writing the run bit again at regular intervals. If no such write arrives before the selected interval runs out, the block raises a timeout response. The response is either a one-cycle system reset request or a non-maskable interrupt (NMI) request. The NMI request stays high until a clear input removes it.

The count has two stages. The lower stage is a free-running prescaler of `LOW_W` bits that a restart never clears. The upper stage counts prescaler carries and is cleared by every restart. Because the prescaler keeps its phase across a restart, a timeout can arrive up to 2^`LOW_W` clocks earlier than the nominal interval.

Once the watchdog is counting, its configuration is frozen until the next reset, so a runaway program cannot switch it off. A low-power stop input freezes both count stages. A halt input has no effect on counting.

Top module: `runaway_wdt`

## Requirements
- R1: While reset is held, and after it is released, both `rst_req_o` and `nmi_o` are low, and no timeout occurs until a starting write arrives.
- R2: A write to address 0 with bit 7 (run) = 1 and bit 4 (enable) = 1 starts counting. If that write has bit 4 = 0, the watchdog stays inactive and never times out.
- R3: Bits 2:0 of a write to address 1 select the interval N = 2^E clocks. Codes 0..6 give E = BASE_EXP+code, and code 7 gives E = BASE_EXP+8. With no restart, a timeout output appears between N−2^LOW_W and N+2 clocks after the last run write.
- R4: A write to address 0 with bit 7 = 1 while counting restarts the interval. Restarts spaced no more than N/2 clocks apart never let a timeout occur.
- R5: With bit 3 (response) = 1 at start, a timeout gives a `rst_req_o` pulse exactly one clock wide, and `nmi_o` stays low.
- R6: With bit 3 = 0 at start, a timeout raises `nmi_o`, which stays high until `clr_nmi_i` is pulsed. `rst_req_o` stays low.
- R7: While `stop_i` is high, neither count stage advances. `halt_i` has no effect on counting.
- R8: Once counting has started, writes to the enable, response and interval fields are ignored until reset.
- R9: When no restart follows a timeout, counting continues, and the next timeout comes exactly N clocks after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = mode register, 1 = interval register |
| wr_data_i | input | 8 | Write data |
| halt_i | input | 1 | Halt mode indication (counting unaffected) |
| stop_i | input | 1 | Stop mode indication (count frozen) |
| clr_nmi_i | input | 1 | One-cycle pulse that clears the NMI request |
| rst_req_o | output | 1 | One-cycle system reset request |
| nmi_o | output | 1 | Non-maskable interrupt request level |

## Verification
The bench builds the block with LOW_W = 2 and BASE_EXP = 4. The ladder then runs from 16 to 4096 clocks and the early-arrival window is four clocks wide. At these values, all eight interval codes can be tested both with timely restarts and with a missed restart, and both response paths fit well inside the run budget. The small prescaler also means a restart often lands near a prescaler carry, so the window edges on both sides are actually reached.

// File: rtl/rwdt_pkg.sv
package rwdt_pkg;

  // Field positions inside the mode register
  localparam int RUN_BIT  = 7;
  localparam int EN_BIT   = 4;
  localparam int RESP_BIT = 3;

  typedef enum logic {
    RESP_NMI = 1'b0,
    RESP_RST = 1'b1
  } resp_e;

  typedef struct packed {
    logic       en;
    resp_e      resp;
    logic [2:0] code;
  } wd_cfg_t;

  // Interval exponent for a code; the ladder skips base+7
  function automatic int ladder_exp(input int code, input int base);
    return (code == 7) ? base + 8 : base + code;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int LOW_W = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic halt_i,
  output logic tick_o
);

  logic [LOW_W-1:0] low_q, low_d;
  logic             adv;

  assign adv    = ~stop_i;
  assign tick_o = adv & (&low_q);

  always_comb begin
    low_d = low_q;
    if (adv) low_d = low_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= '0;
    else        low_q <= low_d;
  end

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> $stable(low_q));

  // R7
  halt_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !stop_i) |=> (low_q == $past(low_q) + 1'b1));

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import rwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic       wr_addr_i,
  input  logic [7:0] wr_data_i,
  output wd_cfg_t    cfg_o,
  output logic       running_o,
  output logic       restart_o
);

  wd_cfg_t cfg_q, cfg_d;
  logic    run_q, run_d;
  logic    mode_wr, sel_wr;
  logic    unused_bits;

  assign unused_bits = ^wr_data_i[6:5];

  assign mode_wr = wr_en_i & ~wr_addr_i;
  assign sel_wr  = wr_en_i &  wr_addr_i;

  // A run write restarts while counting, or starts when enable is set in the same write
  assign restart_o = mode_wr & wr_data_i[RUN_BIT] & (run_q | wr_data_i[EN_BIT]);

  always_comb begin
    cfg_d = cfg_q;
    run_d = run_q;
    if (!run_q) begin
      if (sel_wr) cfg_d.code = wr_data_i[2:0];
      if (mode_wr) begin
        cfg_d.en   = wr_data_i[EN_BIT];
        cfg_d.resp = resp_e'(wr_data_i[RESP_BIT]);
        if (wr_data_i[RUN_BIT] && wr_data_i[EN_BIT]) run_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{en: 1'b0, resp: RESP_NMI, code: 3'd0};
      run_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      run_q <= run_d;
    end
  end

  assign cfg_o     = cfg_q;
  assign running_o = run_q;

  // R8
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> (run_q && $stable(cfg_q)));

  // R2
  start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> cfg_q.en);

endmodule

// File: rtl/wdt_stage.sv
module wdt_stage
  import rwdt_pkg::*;
#(
  parameter int LOW_W    = 11,
  parameter int BASE_EXP = 12,
  parameter int UP_W     = BASE_EXP + 8 - LOW_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic [2:0] code_i,
  output logic       tmo_o
);

  logic [UP_W-1:0] lim_tab [8];
  logic [UP_W-1:0] lim;
  logic [UP_W-1:0] up_q, up_d;
  logic            tmo_q, tmo_d;

  for (genvar g = 0; g < 8; g++) begin : g_lim
    localparam int SHIFT_G = ladder_exp(g, BASE_EXP) - LOW_W;
    assign lim_tab[g] = UP_W'((64'd1 << SHIFT_G) - 64'd1);
  end

  assign lim = lim_tab[code_i];

  always_comb begin
    up_d  = up_q;
    tmo_d = 1'b0;
    if (restart_i) begin
      up_d = '0;
    end else if (run_i && tick_i) begin
      if (up_q == lim) begin
        up_d  = '0;
        tmo_d = 1'b1;
      end else begin
        up_d = up_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= '0;
      tmo_q <= 1'b0;
    end else begin
      up_q  <= up_d;
      tmo_q <= tmo_d;
    end
  end

  assign tmo_o = tmo_q;

  // R3
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (up_q <= lim));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !restart_i) |=> $stable(up_q));

  // R4
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (up_q == '0 && !tmo_q));

endmodule

// File: rtl/runaway_wdt.sv
module runaway_wdt
  import rwdt_pkg::*;
#(
  parameter int LOW_W    = 11,
  parameter int BASE_EXP = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic       wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       halt_i,
  input  logic       stop_i,
  input  logic       clr_nmi_i,
  output logic       rst_req_o,
  output logic       nmi_o
);

  localparam int UP_W = BASE_EXP + 8 - LOW_W;

  logic    sync0_q, sync1_q, srst_n;
  wd_cfg_t cfg;
  logic    running, restart, tick, tmo;
  logic    rreq_q, rreq_d, nmi_q, nmi_d;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync0_q <= 1'b0;
      sync1_q <= 1'b0;
    end else begin
      sync0_q <= 1'b1;
      sync1_q <= sync0_q;
    end
  end
  assign srst_n = sync1_q;

  wdt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .running_o (running),
    .restart_o (restart)
  );

  wdt_prescaler #(.LOW_W(LOW_W)) u_pre (
    .clk    (clk),
    .rst_n  (srst_n),
    .stop_i (stop_i),
    .halt_i (halt_i),
    .tick_o (tick)
  );

  wdt_stage #(.LOW_W(LOW_W), .BASE_EXP(BASE_EXP), .UP_W(UP_W)) u_stage (
    .clk       (clk),
    .rst_n     (srst_n),
    .tick_i    (tick),
    .run_i     (running),
    .restart_i (restart),
    .code_i    (cfg.code),
    .tmo_o     (tmo)
  );

  always_comb begin
    rreq_d = tmo & (cfg.resp == RESP_RST);
    nmi_d  = nmi_q;
    if (clr_nmi_i) nmi_d = 1'b0;
    if (tmo && cfg.resp == RESP_NMI) nmi_d = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rreq_q <= 1'b0;
      nmi_q  <= 1'b0;
    end else begin
      rreq_q <= rreq_d;
      nmi_q  <= nmi_d;
    end
  end

  assign rst_req_o = rreq_q;
  assign nmi_o     = nmi_q;

  // R5
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req_o |=> !rst_req_o);

  // R6
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (nmi_o && !clr_nmi_i) |=> nmi_o);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !running |=> (!rst_req_o && !$rose(nmi_o)));

endmodule

// File: tb/test_runaway_wdt.sv
module test_runaway_wdt;

  localparam int LW   = 2;
  localparam int BASE = 4;
  localparam int SLOP = 1 << LW;

  typedef struct packed {
    logic [2:0] code;
    logic       resp;
    logic [7:0] expo;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{3'd0, 1'b1, 8'd4},  '{3'd1, 1'b0, 8'd5},
    '{3'd2, 1'b1, 8'd6},  '{3'd3, 1'b0, 8'd7},
    '{3'd4, 1'b1, 8'd8},  '{3'd5, 1'b0, 8'd9},
    '{3'd6, 1'b1, 8'd10}, '{3'd7, 1'b0, 8'd12}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic halt = 1'b0, stop = 1'b0, clr_nmi = 1'b0;
  logic rst_req, nmi;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  runaway_wdt #(.LOW_W(LW), .BASE_EXP(BASE)) i_runaway_wdt (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .halt_i    (halt),
    .stop_i    (stop),
    .clr_nmi_i (clr_nmi),
    .rst_req_o (rst_req),
    .nmi_o     (nmi)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic wait_evt(input int maxc, output int cyc, output bit sr, output bit sn);
    cyc = 0; sr = 1'b0; sn = 1'b0;
    while (cyc < maxc && !sr && !sn) begin
      @(negedge clk);
      cyc++;
      sr = rst_req;
      sn = nmi;
    end
  endtask

  initial begin
    int c;
    bit sr, sn;
    int n;

    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!rst_req && !nmi, "R1 in reset", {rst_req, nmi}, 0);
    do_reset();
    check(!rst_req && !nmi, "R1 after reset", {rst_req, nmi}, 0);
    wait_evt(300, c, sr, sn);
    check(!sr && !sn, "R1 no event before start", {sr, sn}, 0);

    // R2: run without enable leaves watchdog inactive
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h88);
    wait_evt(300, c, sr, sn);
    check(!sr && !sn, "R2 run with enable=0", {sr, sn}, 0);

    // Table walk: R3, R4, R5, R6 for every code
    for (int i = 0; i < 8; i++) begin
      n = 1 << TBL[i].expo;
      do_reset();
      wr(1'b1, {5'b0, TBL[i].code});
      wr(1'b0, 8'h90 | (8'(TBL[i].resp) << 3));
      for (int k = 0; k < 3; k++) begin
        wait_evt(n / 2, c, sr, sn);
        check(!sr && !sn, "R4 timely restart", {sr, sn}, 0);
        wr(1'b0, 8'h80);
      end
      wait_evt(n + 20, c, sr, sn);
      check(c >= n - SLOP && c <= n + 2, "R3 timeout window", c, n);
      if (TBL[i].resp) begin
        check(sr && !sn, "R5 reset path", {sr, sn}, 2);
        @(negedge clk);
        check(!rst_req && !nmi, "R5 one-cycle pulse", {rst_req, nmi}, 0);
      end else begin
        check(sn && !sr, "R6 nmi path", {sr, sn}, 1);
        repeat (10) @(negedge clk);
        check(nmi && !rst_req, "R6 nmi held", {rst_req, nmi}, 1);
        clr_nmi = 1'b1;
        @(negedge clk);
        clr_nmi = 1'b0;
        check(!nmi, "R6 nmi cleared", nmi, 0);
      end
    end

    // R9: periodic timeouts without restart, reset response, code 0
    do_reset();
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h98);
    wait_evt(40, c, sr, sn);
    check(sr, "R9 first timeout", sr, 1);
    wait_evt(40, c, sr, sn);
    check(sr && c == 16, "R9 period", c, 16);

    // R8: configuration locked after start
    do_reset();
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h98);
    wr(1'b1, 8'h07);
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h80);
    wait_evt(200, c, sr, sn);
    check(c >= 16 - SLOP && c <= 18, "R8 interval kept", c, 16);
    check(sr && !sn, "R8 response kept", {sr, sn}, 2);

    // R7: stop freezes the count
    do_reset();
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h98);
    repeat (5) @(negedge clk);
    stop = 1'b1;
    wait_evt(300, c, sr, sn);
    check(!sr && !sn, "R7 frozen during stop", {sr, sn}, 0);
    stop = 1'b0;
    wait_evt(100, c, sr, sn);
    check(sr && (c + 5) >= 32 - SLOP - 1 && (c + 5) <= 32 + 3, "R7 resumes after stop", c + 5, 32);

    // R7: halt leaves counting untouched
    do_reset();
    halt = 1'b1;
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h98);
    wait_evt(100, c, sr, sn);
    check(sr && c >= 16 - SLOP && c <= 18, "R7 halt no effect", c, 16);
    halt = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule